// File: doc/BRIEF.md
# Programmable SPI Master Character Engine

The engine drives one serial character per transfer as the master of an SPI link. A character is 4 to 16 bits long, selected by a 4-bit length code holding the bit count minus one. The serial clock comes from the reference clock through a two-stage divider. It has a 50% duty cycle and a period of 4·(P+1) reference cycles, where P is a 4-bit prescale code. A phase input chooses where clocking begins inside the first bit: mid-bit or at the first instant. A polarity input chooses the idle level of the clock.

The host places a right-justified word on `tx_data`, sets the configuration inputs and pulses `start`. The engine captures the configuration and the word on that edge. It lowers `ss_n`, shifts the character out most significant bit first on `mosi`, and shifts `miso` into a receive register. At the end it releases `ss_n` and pulses `done` for one cycle. At that moment `rx_data` carries the received character, right-justified.

The control is a four-state machine. State `SPIM_IDLE` waits for a strobe. `SPIM_LAUNCH` covers the half of a bit time in which data is presented. `SPIM_CAPTURE` covers the half in which the master has sampled. `SPIM_DONE` is the one-cycle completion state. The transitions are:
- IDLE→LAUNCH on an accepted strobe.
- LAUNCH→CAPTURE on a half-period tick, where `miso` is sampled.
- CAPTURE→LAUNCH on a tick when bits remain, where the next bit is shifted out.
- CAPTURE→DONE on a tick after the last bit.
- DONE→LAUNCH on a strobe.
- DONE→IDLE otherwise.

Top module: `spim_char_engine`

## Requirements
- R1: The length code L gives L+1 bits per character. Bits of `tx_data` from bit L down to bit 0 appear on `mosi` most significant first, and bits above L have no effect on the line.
- R2: A length code below 3 transfers 4 bits. `cfg_err` is high exactly when the length code captured at the last idle cycle is below 3, and it holds that value through a transfer.
- R3: At `done`, `rx_data[L:0]` holds the received bits with the first received bit in position L, and all higher bits are 0. `rx_data` keeps its value until the next `done`.
- R4: Each half period of `sclk` lasts 2·(P+1) reference cycles, and `ss_n` stays low for exactly 2·(L+1)·2·(P+1) cycles per transfer, with 2·(L+1) `sclk` transitions.
- R5: With phase 0, `sclk` first toggles one half period after `ss_n` falls. `miso` is sampled on leading edges and `mosi` changes on trailing edges.
- R6: With phase 1, `sclk` makes its first toggle on the same edge that lowers `ss_n`. `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R7: While `ss_n` is high, `sclk` sits at the polarity level: 0 for polarity 0 and 1 for polarity 1.
- R8: `busy` rises on the edge that accepts a strobe and is high exactly while `ss_n` is low.
- R9: `done` is a single-cycle pulse, issued in the first cycle with `ss_n` high after a transfer, with `busy` low.
- R10: A strobe while `busy` is high is ignored, and the transfer in flight continues unchanged.
- R11: Configuration and `tx_data` are captured on the accepting edge. Changes to them during a transfer have no effect on it.
- R12: A strobe in the `done` cycle is accepted at once, and `ss_n` is then high for exactly one cycle between the two characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer strobe |
| tx_data | input | 16 | Right-justified transmit character |
| len_code | input | 4 | Bits per character minus one |
| pre_code | input | 4 | Prescale code P, clock ratio 4·(P+1) |
| cpha | input | 1 | Phase select: 0 mid-bit start, 1 immediate start |
| cpol | input | 1 | Idle level of the serial clock |
| rx_data | output | 16 | Right-justified received character |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Length code below the legal minimum |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low select |

## Verification
Two events can share a cycle. One is the completion of a character: the `done` pulse and the receive commit. The other is the acceptance of the next strobe, and it happens when the host answers `done` with a new strobe in the same cycle. The bench provokes this by raising `start` at the sampling point where it first sees `done`. It then judges that `ss_n` is low again one cycle later, and that both characters arrive intact at the slave model and in `rx_data`. A second overlap is a strobe that arrives during a transfer together with changed configuration inputs. The bench judges that one by the select window length, the edge count and the data, all of which must match the original settings.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;

    typedef enum logic [1:0] {
        SPIM_IDLE    = 2'd0,
        SPIM_LAUNCH  = 2'd1,
        SPIM_CAPTURE = 2'd2,
        SPIM_DONE    = 2'd3
    } spim_state_e;

endpackage

// File: rtl/spim_cfg_hold.sv
`timescale 1ns/1ps
// Holds the per-transfer configuration. Loads on every non-busy cycle so that
// the accepting edge captures the inputs present with the strobe.
module spim_cfg_hold #(
    parameter int LEN_W        = 4,
    parameter int PRE_W        = 4,
    parameter int MIN_LEN_CODE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [LEN_W-1:0] len_code,
    input  logic [PRE_W-1:0] pre_code,
    input  logic             cpha_in,
    input  logic             cpol_in,
    output logic [LEN_W-1:0] load_len,
    output logic [LEN_W-1:0] len_q,
    output logic [PRE_W-1:0] pre_q,
    output logic             cpha_q,
    output logic             cpol_q,
    output logic             cfg_err
);
    localparam logic [LEN_W-1:0] MIN_CODE = LEN_W'(MIN_LEN_CODE);

    logic code_bad;

    // Clamp an illegal short code to the shortest legal character.
    always_comb begin
        code_bad = (len_code < MIN_CODE);
        load_len = code_bad ? MIN_CODE : len_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= MIN_CODE;
            pre_q   <= '0;
            cpha_q  <= 1'b0;
            cpol_q  <= 1'b0;
            cfg_err <= 1'b0;
        end else if (load_en) begin
            len_q   <= load_len;
            pre_q   <= pre_code;
            cpha_q  <= cpha_in;
            cpol_q  <= cpol_in;
            cfg_err <= code_bad;
        end
    end

endmodule

// File: rtl/spim_prescaler.sv
`timescale 1ns/1ps
// Two-stage divider: a modulo-(P+1) counter followed by a divide-by-two.
// half_tick marks the last cycle of each serial half period, 2*(P+1) long.
module spim_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PRE_W-1:0] pre,
    output logic             half_tick
);
    logic [PRE_W-1:0] cnt_q;
    logic             div2_q;
    logic             wrap;

    always_comb begin
        wrap      = (cnt_q == pre);
        half_tick = wrap && div2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            div2_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            div2_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            div2_q <= ~div2_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
// Transmit and receive shift registers. The transmit word is left-justified
// at load so the character's top bit always leaves from the MSB.
module spim_shifter #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [LEN_W-1:0]  run_len,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              shift,
    input  logic              sample,
    input  logic              commit,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] keep_mask;

    always_comb begin
        keep_mask = ~({DATA_W{1'b1}} << (int'(run_len) + 1));
        mosi      = tx_sr[DATA_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            rx_data <= '0;
        end else begin
            if (load) begin
                tx_sr <= tx_data << (DATA_W - 1 - int'(load_len));
                rx_sr <= '0;
            end else begin
                if (shift) begin
                    tx_sr <= tx_sr << 1;
                end
                if (sample) begin
                    rx_sr <= {rx_sr[DATA_W-2:0], miso};
                end
            end
            if (commit) begin
                rx_data <= rx_sr & keep_mask;
            end
        end
    end

endmodule

// File: rtl/spim_fsm.sv
`timescale 1ns/1ps
// Transfer sequencer. LAUNCH is the half bit in which data is presented,
// CAPTURE the half bit after the master has sampled. The serial clock level
// follows from the state, the phase and the polarity.
module spim_fsm
    import spim_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             half_tick,
    input  logic [LEN_W-1:0] len_q,
    input  logic             cpha_q,
    input  logic             cpol_q,
    output logic             busy,
    output logic             ss_n,
    output logic             sclk,
    output logic             done,
    output logic             load,
    output logic             sample,
    output logic             shift,
    output logic             commit
);
    spim_state_e      state_q;
    spim_state_e      state_d;
    logic [LEN_W-1:0] bit_q;
    logic             last_bit;
    logic             accept;

    always_comb begin
        last_bit = (bit_q == len_q);
        accept   = start && ((state_q == SPIM_IDLE) || (state_q == SPIM_DONE));
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SPIM_IDLE: begin
                if (start) state_d = SPIM_LAUNCH;
            end
            SPIM_LAUNCH: begin
                if (half_tick) state_d = SPIM_CAPTURE;
            end
            SPIM_CAPTURE: begin
                if (half_tick) state_d = last_bit ? SPIM_DONE : SPIM_LAUNCH;
            end
            SPIM_DONE: begin
                state_d = start ? SPIM_LAUNCH : SPIM_IDLE;
            end
        endcase
    end

    // State register and bit counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SPIM_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                bit_q <= '0;
            end else if (shift) begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    // Output decode.
    always_comb begin
        busy   = 1'b0;
        done   = 1'b0;
        sample = 1'b0;
        shift  = 1'b0;
        commit = 1'b0;
        sclk   = cpol_q;
        unique case (state_q)
            SPIM_IDLE: begin
            end
            SPIM_LAUNCH: begin
                busy   = 1'b1;
                sclk   = cpol_q ^ cpha_q;
                sample = half_tick;
            end
            SPIM_CAPTURE: begin
                busy   = 1'b1;
                sclk   = cpol_q ^ ~cpha_q;
                shift  = half_tick && !last_bit;
                commit = half_tick && last_bit;
            end
            SPIM_DONE: begin
                done = 1'b1;
            end
        endcase
        ss_n = ~busy;
        load = accept;
    end

endmodule

// File: rtl/spim_char_engine.sv
`timescale 1ns/1ps
module spim_char_engine #(
    parameter int DATA_W       = 16,
    parameter int LEN_W        = 4,
    parameter int PRE_W        = 4,
    parameter int MIN_LEN_CODE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [LEN_W-1:0]  len_code,
    input  logic [PRE_W-1:0]  pre_code,
    input  logic              cpha,
    input  logic              cpol,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              done,
    output logic              cfg_err,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n
);
    logic [LEN_W-1:0] load_len;
    logic [LEN_W-1:0] len_eff_q;
    logic [PRE_W-1:0] pre_q;
    logic             cpha_q;
    logic             cpol_q;
    logic             half_tick;
    logic             load;
    logic             sample;
    logic             shift;
    logic             commit;

    spim_cfg_hold #(
        .LEN_W       (LEN_W),
        .PRE_W       (PRE_W),
        .MIN_LEN_CODE(MIN_LEN_CODE)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (~busy),
        .len_code(len_code),
        .pre_code(pre_code),
        .cpha_in (cpha),
        .cpol_in (cpol),
        .load_len(load_len),
        .len_q   (len_eff_q),
        .pre_q   (pre_q),
        .cpha_q  (cpha_q),
        .cpol_q  (cpol_q),
        .cfg_err (cfg_err)
    );

    spim_prescaler #(
        .PRE_W(PRE_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (~busy),
        .pre      (pre_q),
        .half_tick(half_tick)
    );

    spim_fsm #(
        .LEN_W(LEN_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .half_tick(half_tick),
        .len_q    (len_eff_q),
        .cpha_q   (cpha_q),
        .cpol_q   (cpol_q),
        .busy     (busy),
        .ss_n     (ss_n),
        .sclk     (sclk),
        .done     (done),
        .load     (load),
        .sample   (sample),
        .shift    (shift),
        .commit   (commit)
    );

    spim_shifter #(
        .DATA_W(DATA_W),
        .LEN_W (LEN_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_len(load_len),
        .run_len (len_eff_q),
        .tx_data (tx_data),
        .shift   (shift),
        .sample  (sample),
        .commit  (commit),
        .miso    (miso),
        .mosi    (mosi),
        .rx_data (rx_data)
    );

endmodule

// File: rtl/spim_char_engine_chk.sv
`timescale 1ns/1ps
module spim_char_engine_chk #(
    parameter int DATA_W       = 16,
    parameter int LEN_W        = 4,
    parameter int MIN_LEN_CODE = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              ss_n,
    input logic              sclk,
    input logic              cpol_q,
    input logic [LEN_W-1:0]  len_code,
    input logic [LEN_W-1:0]  len_eff_q,
    input logic              cfg_err,
    input logic [DATA_W-1:0] rx_data
);
    p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ss_n && !busy));

    p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> (sclk == cpol_q));

    p_cfg_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (cfg_err == ($past(len_code) < LEN_W'(MIN_LEN_CODE))));

    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(len_eff_q));

    p_rx_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rx_data >> (int'(len_eff_q) + 1)) == '0));

endmodule

bind spim_char_engine spim_char_engine_chk #(
    .DATA_W      (DATA_W),
    .LEN_W       (LEN_W),
    .MIN_LEN_CODE(MIN_LEN_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ss_n     (ss_n),
    .sclk     (sclk),
    .cpol_q   (cpol_q),
    .len_code (len_code),
    .len_eff_q(len_eff_q),
    .cfg_err  (cfg_err),
    .rx_data  (rx_data)
);

// File: tb/spim_char_engine_tb.sv
`timescale 1ns/1ps
module spim_char_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tx_data = '0;
    logic [3:0]  len_code = 4'd7;
    logic [3:0]  pre_code = '0;
    logic        cpha = 1'b0;
    logic        cpol = 1'b0;
    logic [15:0] rx_data;
    logic        busy;
    logic        done;
    logic        cfg_err;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;
    logic        ss_n;

    int checks = 0;
    int fails  = 0;

    // Settings of the transfer in flight, as the bench expects them.
    int          g_lc, g_pc;
    logic        g_cpha, g_cpol;
    logic [15:0] g_tx, g_pat;
    logic [15:0] slv_sr, slv_cap;
    int          cap_cnt;

    always #10 clk = ~clk;

    spim_char_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
        .len_code(len_code), .pre_code(pre_code), .cpha(cpha), .cpol(cpol),
        .rx_data(rx_data), .busy(busy), .done(done), .cfg_err(cfg_err),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    function automatic int eff_bits(input int lc);
        return (lc < 3) ? 4 : lc + 1;
    endfunction

    function automatic logic [15:0] low_mask(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Drive a strobe with the given settings; returns at the first sampling
    // point after the accepting edge.
    task automatic launch(input logic [15:0] tx, input logic [15:0] pat,
                          input int lc, input int pc, input logic ph, input logic pl);
        @(negedge clk);
        tx_data = tx; len_code = 4'(lc); pre_code = 4'(pc);
        cpha = ph; cpol = pl; start = 1'b1;
        g_tx = tx; g_pat = pat; g_lc = lc; g_pc = pc; g_cpha = ph; g_cpol = pl;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Acts as the slave and monitors one whole transfer, sample by sample.
    task automatic observe(input bit poke, input bit chain,
                           input logic [15:0] ntx, input logic [15:0] npat);
        int   n = eff_bits(g_lc);
        int   h = 2 * (g_pc + 1);
        int   k = 0, low = 0, trans = 0, first = -1, lastt = -1;
        int   gap_bad = 0, busy_bad = 0;
        logic prev_sclk = g_cpol;
        logic prev_ss = 1'b1;
        logic lead;
        logic [15:0] saved_tx = tx_data;
        slv_sr = g_pat << (16 - n);
        slv_cap = '0;
        cap_cnt = 0;
        while (1) begin
            k++;
            if (k > 5000) begin
                chk(1'b0, "R4", "transfer watchdog", k, 2 * n * h);
                break;
            end
            if (ss_n != !busy) busy_bad++;
            if (!ss_n) low++;
            if (prev_ss && !ss_n && !g_cpha) begin
                miso = slv_sr[15];
                slv_sr = slv_sr << 1;
            end
            if (sclk != prev_sclk) begin
                trans++;
                if (first < 0) first = k;
                else if (k - lastt != h) gap_bad++;
                lastt = k;
                lead = (prev_sclk == g_cpol);
                if (lead ^ g_cpha) begin
                    slv_cap = {slv_cap[14:0], mosi};
                    cap_cnt++;
                end else begin
                    miso = slv_sr[15];
                    slv_sr = slv_sr << 1;
                end
            end
            prev_sclk = sclk;
            prev_ss = ss_n;
            // R10/R11: strobe and altered settings mid-transfer.
            if (poke && k == h + 1) begin
                start = 1'b1; tx_data = ~saved_tx; len_code = 4'd15;
                pre_code = 4'(g_pc + 3); cpha = ~g_cpha; cpol = ~g_cpol;
            end
            if (poke && k == h + 2) begin
                start = 1'b0; tx_data = saved_tx; len_code = 4'(g_lc);
                pre_code = 4'(g_pc); cpha = g_cpha; cpol = g_cpol;
            end
            if (done) begin
                chk(low == 2 * n * h, "R4", "select low cycles", low, 2 * n * h);
                chk(trans == 2 * n, "R4", "sclk transitions", trans, 2 * n);
                chk(gap_bad == 0, "R4", "half-period spacing errors", gap_bad, 0);
                if (g_cpha)
                    chk(first == 1, "R6", "first toggle sample", first, 1);
                else
                    chk(first == h + 1, "R5", "first toggle sample", first, h + 1);
                chk(cap_cnt == n, "R1", "bits seen by slave", cap_cnt, n);
                chk(slv_cap == (g_tx & low_mask(n)), "R1", "mosi character",
                    slv_cap, g_tx & low_mask(n));
                chk(rx_data == (g_pat & low_mask(n)), "R3", "rx_data",
                    rx_data, g_pat & low_mask(n));
                chk(busy_bad == 0, "R8", "busy vs select mismatches", busy_bad, 0);
                chk(cfg_err == (g_lc < 3), "R2", "cfg_err", cfg_err, g_lc < 3);
                chk(ss_n && !busy, "R9", "select/busy at done", {ss_n, busy}, 2'b10);
                chk(sclk == g_cpol, "R7", "idle sclk level", sclk, g_cpol);
                break;
            end
            @(negedge clk);
        end
        if (chain) begin
            start = 1'b1; tx_data = ntx; g_tx = ntx; g_pat = npat;
            @(negedge clk);
            start = 1'b0;
            chk(!done && !ss_n, "R12", "back-to-back select", {done, ss_n}, 2'b00);
        end else begin
            @(negedge clk);
            chk(!done, "R9", "done after one cycle", done, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WD", "global watchdog", 0, 1);
        report();
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'h51A7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ss_n && !busy && !done, "R8", "reset outputs", {ss_n, busy, done}, 3'b100);
        chk(rx_data == 0 && !cfg_err, "R3", "reset rx/cfg_err", rx_data, 0);
        chk(sclk == 1'b0, "R7", "reset idle sclk", sclk, 0);

        // R7: idle level follows polarity while idle.
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R7", "idle sclk high", sclk, 1);

        // Directed corners.
        launch(16'h00A5, 16'h003C, 7, 0, 1'b0, 1'b0);  observe(0, 0, '0, '0);
        launch(16'h005A, 16'h00C3, 7, 1, 1'b1, 1'b1);  observe(0, 0, '0, '0);
        launch(16'hBEEF, 16'h1234, 15, 15, 1'b0, 1'b1); observe(0, 0, '0, '0);
        launch(16'hFFF9, 16'hFFF6, 3, 0, 1'b1, 1'b0);  observe(0, 0, '0, '0);   // R1 upper bits ignored
        launch(16'h000D, 16'hABC5, 1, 2, 1'b0, 1'b0);  observe(0, 0, '0, '0);   // R2 illegal code
        launch(16'h0007, 16'h0009, 0, 0, 1'b1, 1'b1);  observe(0, 0, '0, '0);   // R2 code zero
        launch(16'h01C3, 16'h0155, 8, 1, 1'b0, 1'b0);  observe(1, 0, '0, '0);   // R10, R11
        launch(16'h01C3, 16'h0155, 8, 0, 1'b1, 1'b0);  observe(1, 0, '0, '0);   // R10, R11

        // R12: answer done with a new strobe in the same cycle.
        launch(16'h0A5A, 16'h05A5, 11, 0, 1'b0, 1'b1); observe(0, 1, 16'h0F0F, 16'h0C3C);
        observe(0, 0, '0, '0);
        launch(16'h3333, 16'h4444, 13, 1, 1'b1, 1'b0); observe(0, 1, 16'h2222, 16'h1111);
        observe(0, 0, '0, '0);

        // R3: received word held across idle time.
        held = rx_data;
        repeat (6) @(negedge clk);
        chk(rx_data == held, "R3", "rx_data held while idle", rx_data, held);

        // Random transfers.
        for (int i = 0; i < 36; i++) begin
            launch(16'($urandom), 16'($urandom), int'($urandom_range(0, 15)),
                   int'($urandom_range(0, 15)), 1'($urandom), 1'($urandom));
            observe(1'($urandom_range(0, 3) == 0), 0, '0, '0);
        end
        report();
    end

endmodule